// File: doc/BRIEF.md
# Phase-Accumulator Clock Synthesizer

This block turns a fast system clock into a slower square-wave clock on a single output pin. A 32-bit phase accumulator is advanced by a programmable increment. The pin always shows the accumulator's most significant bit, so the average output frequency is the system frequency times increment / 2^32. For example, an increment of 0x4CCCCCCD gives very nearly 24 MHz from an 80 MHz system clock.

A base-period divider slows the accumulator down. The accumulator is stepped only once every `period` system clocks, so the output frequency is additionally divided by that value. Output edges can only land on system clock edges. When the ratio is not a whole number, as with 3 1/3 clocks per output cycle, the waveform carries one-clock jitter but keeps the correct average rate.

Each wrap of the accumulator raises a sticky event flag. Software clears the flag with a one-cycle acknowledge pulse. Dropping the drive-enable input holds the whole block in its cleared state.

Top module: `nco_clkgen`

## Requirements
- R1: While `drive_en_i` is low (or `rst_n` is low), the next clock edge leaves the accumulator at zero, `clk_pin_o` low and `wrap_evt_o` low. After enable rises, accumulation starts from zero.
- R2: At each base-period boundary, the accumulator becomes (accumulator + `incr_i`) mod 2^32. The increment used is the value present in that boundary cycle.
- R3: `clk_pin_o` always equals bit 31 of the accumulator. With `incr_i` < 2^31, after n updates from zero the number of high-to-low transitions on the pin is exactly floor(n·incr/2^32).
- R4: The wrap event becomes high on the clock edge at which an update carries out of bit 31.
- R5: With `period_i` = P ≥ 1, updates happen once every P system clocks. The first update happens on the P-th rising edge after enable is sampled high. Between updates the accumulator holds its value.
- R6: A `period_i` value of 0 behaves exactly like a value of 1, meaning one update per system clock.
- R7: `wrap_evt_o` stays high until a cycle with `evt_ack_i` high clears it. If a new wrap coincides with the acknowledge, the flag stays high.
- R8: With a non-integer clock ratio, such as increment 0x4CCCCCCD at period 1, successive rising edges of the pin are 3 or 4 system clocks apart.
- R9: Changing `incr_i` while running does not clear the accumulator. The new value is first used at the next base-period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drive_en_i | input | 1 | Pin drive enable; low holds the block cleared |
| period_i | input | 16 | Base period in system clocks (0 treated as 1) |
| incr_i | input | 32 | Phase increment added per base period |
| evt_ack_i | input | 1 | One-cycle pulse that clears the wrap flag |
| clk_pin_o | output | 1 | Synthesized clock, accumulator bit 31 |
| wrap_evt_o | output | 1 | Sticky accumulator-wrap flag |

## Verification
The assertions assume that `drive_en_i`, `period_i`, `incr_i` and `evt_ack_i` are synchronous to `clk` and stable across each rising edge. They also assume that the base-period counter starts from zero whenever enable rises. The stimulus guarantees this by changing every input only on the falling clock edge. It also drops enable, or holds reset, before each new scenario. Period and increment are changed while running only in scenarios written to test that case. A per-edge reference model, built from the requirements, follows every such change.

// File: rtl/nco_pkg.sv
package nco_pkg;
    localparam int unsigned DEF_PER_W = 16;
    localparam int unsigned DEF_ACC_W = 32;

    typedef struct packed {
        logic flag;
    } evt_state_t;
endpackage

// File: rtl/nco_tick.sv
module nco_tick #(
    parameter int unsigned PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [PER_W-1:0] period_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [PER_W-1:0] cnt;
    } tick_state_t;

    tick_state_t st_q, st_d;
    logic [PER_W-1:0] last_cnt;

    always_comb begin
        // a period of 0 is folded onto 1, so the last count is 0 in both cases
        last_cnt = (period_i == '0) ? '0 : period_i - 1'b1;
        tick_o   = en_i && (st_q.cnt >= last_cnt);
        st_d     = st_q;
        if (!en_i) begin
            st_d.cnt = '0;
        end else if (tick_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6
    tick_unit_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && period_i <= 1 && st_q.cnt == '0) |-> tick_o);

    // R5
    tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i) |=> (st_q.cnt == '0));
endmodule

// File: rtl/nco_accum.sv
module nco_accum #(
    parameter int unsigned ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic [ACC_W-1:0] incr_i,
    output logic [ACC_W-1:0] phase_o,
    output logic             carry_o
);
    typedef struct packed {
        logic [ACC_W-1:0] phase;
    } acc_state_t;

    acc_state_t st_q, st_d;
    logic [ACC_W:0] sum;

    always_comb begin
        sum     = {1'b0, st_q.phase} + {1'b0, incr_i};
        carry_o = en_i && tick_i && sum[ACC_W];
        st_d    = st_q;
        if (!en_i) begin
            st_d.phase = '0;
        end else if (tick_i) begin
            st_d.phase = sum[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase_o = st_q.phase;

    // R1
    acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i) |=> (phase_o == '0));

    // R5
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !tick_i) |=> $stable(phase_o));

    // R2
    acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && tick_i) |=> (phase_o == $past(phase_o) + $past(incr_i)));
endmodule

// File: rtl/nco_event.sv
module nco_event
    import nco_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic set_i,
    input  logic ack_i,
    output logic flag_o
);
    evt_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d.flag = 1'b0;
        end else if (set_i) begin
            st_d.flag = 1'b1;
        end else if (ack_i) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    // R7
    evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && flag_o && !ack_i) |=> flag_o);

    // R4
    evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && set_i) |=> flag_o);

    // R1
    evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i) |=> !flag_o);
endmodule

// File: rtl/nco_clkgen.sv
module nco_clkgen
    import nco_pkg::*;
#(
    parameter int unsigned PER_W = DEF_PER_W,
    parameter int unsigned ACC_W = DEF_ACC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drive_en_i,
    input  logic [PER_W-1:0] period_i,
    input  logic [ACC_W-1:0] incr_i,
    input  logic             evt_ack_i,
    output logic             clk_pin_o,
    output logic             wrap_evt_o
);
    localparam int unsigned MSB = ACC_W - 1;

    logic             tick;
    logic             carry;
    logic [ACC_W-1:0] phase;

    nco_tick #(.PER_W(PER_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (drive_en_i),
        .period_i(period_i),
        .tick_o  (tick)
    );

    nco_accum #(.ACC_W(ACC_W)) u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (drive_en_i),
        .tick_i (tick),
        .incr_i (incr_i),
        .phase_o(phase),
        .carry_o(carry)
    );

    nco_event u_event (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (drive_en_i),
        .set_i (carry),
        .ack_i (evt_ack_i),
        .flag_o(wrap_evt_o)
    );

    assign clk_pin_o = phase[MSB];

    // R3
    pin_low_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!drive_en_i) |=> !clk_pin_o);

    // R3
    pin_fall_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en_i && $past(drive_en_i) && $fell(clk_pin_o)) |-> wrap_evt_o);
endmodule

// File: tb/sim_nco_clkgen.sv
`timescale 1ns/1ps
module sim_nco_clkgen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        drive_en_i = 1'b0;
    logic [15:0] period_i = 16'd1;
    logic [31:0] incr_i = '0;
    logic        evt_ack_i = 1'b0;
    logic        clk_pin_o;
    logic        wrap_evt_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    nco_clkgen u0 (
        .clk(clk), .rst_n(rst_n), .drive_en_i(drive_en_i), .period_i(period_i),
        .incr_i(incr_i), .evt_ack_i(evt_ack_i),
        .clk_pin_o(clk_pin_o), .wrap_evt_o(wrap_evt_o)
    );

    // reference model written from the requirements
    logic [15:0] m_cnt = '0;
    logic [31:0] m_acc = '0;
    logic        m_evt = 1'b0;
    always @(posedge clk) begin
        logic [15:0] p;
        logic [32:0] s;
        logic        cy;
        if (!rst_n || !drive_en_i) begin
            m_cnt = '0; m_acc = '0; m_evt = 1'b0;
        end else begin
            p  = (period_i == 16'd0) ? 16'd1 : period_i;
            cy = 1'b0;
            if (m_cnt + 16'd1 >= p) begin
                m_cnt = '0;
                s = {1'b0, m_acc} + {1'b0, incr_i};
                m_acc = s[31:0];
                cy = s[32];
            end else begin
                m_cnt = m_cnt + 16'd1;
            end
            m_evt = cy | (m_evt & ~evt_ack_i);
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    int falls;
    int last_rise;
    int cyc;
    int min_gap;
    int max_gap;
    logic prev_pin;

    // one cycle: move to the falling edge, compare, track edges
    task automatic step(input string req);
        @(negedge clk);
        cyc++;
        chk(clk_pin_o == m_acc[31], req, clk_pin_o, m_acc[31]);
        chk(wrap_evt_o == m_evt, req, wrap_evt_o, m_evt);
        if (prev_pin && !clk_pin_o) falls++;
        if (!prev_pin && clk_pin_o) begin
            if (last_rise >= 0) begin
                if (cyc - last_rise < min_gap) min_gap = cyc - last_rise;
                if (cyc - last_rise > max_gap) max_gap = cyc - last_rise;
            end
            last_rise = cyc;
        end
        prev_pin = clk_pin_o;
    endtask

    task automatic restart(input logic [15:0] per, input logic [31:0] inc);
        @(negedge clk);
        drive_en_i = 1'b0;
        evt_ack_i = 1'b0;
        @(negedge clk);
        chk(clk_pin_o == 1'b0 && wrap_evt_o == 1'b0, "R1", {clk_pin_o, wrap_evt_o}, 0);
        period_i = per;
        incr_i = inc;
        drive_en_i = 1'b1;
        falls = 0; cyc = 0; last_rise = -1; min_gap = 1000; max_gap = 0; prev_pin = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(clk_pin_o == 1'b0, "R1 reset pin", clk_pin_o, 0);
        chk(wrap_evt_o == 1'b0, "R1 reset evt", wrap_evt_o, 0);
        rst_n = 1'b1;
        incr_i = 32'h8000_0000;
        repeat (4) @(negedge clk);
        chk(clk_pin_o == 1'b0, "R1 disabled pin", clk_pin_o, 0);
    endtask

    task automatic t_exact_p1();
        restart(16'd1, 32'h3000_0000);
        for (int i = 0; i < 160; i++) step("R2");
        chk(falls == 30, "R3 exact count p1", falls, 30);
    endtask

    task automatic t_exact_p3();
        restart(16'd3, 32'h6000_0000);
        step("R5");
        step("R5");
        chk(clk_pin_o == 1'b0, "R5 no update before P edges", clk_pin_o, 0);
        step("R5");
        chk(clk_pin_o == 1'b0, "R5 first update value", clk_pin_o, 0);
        for (int i = 3; i < 240; i++) step("R5");
        chk(falls == 30, "R5 exact count p3", falls, 30);
    endtask

    task automatic t_zero_period();
        restart(16'd0, 32'h4000_0000);
        step("R6");
        step("R6");
        chk(clk_pin_o == 1'b1, "R6 period0 as 1", clk_pin_o, 1);
        for (int i = 2; i < 40; i++) step("R6");
        chk(falls == 10, "R6 count", falls, 10);
    endtask

    task automatic t_frac();
        longint exp;
        restart(16'd1, 32'h4CCC_CCCD);
        for (int i = 0; i < 3000; i++) step("R8");
        exp = (longint'(3000) * longint'(32'h4CCC_CCCD)) >>> 32;
        chk(falls == exp, "R3 fractional count", falls, exp);
        chk(min_gap == 3, "R8 min gap", min_gap, 3);
        chk(max_gap == 4, "R8 max gap", max_gap, 4);
    endtask

    task automatic t_event();
        restart(16'd1, 32'h8000_0000);
        step("R4");
        chk(wrap_evt_o == 1'b0, "R4 no wrap yet", wrap_evt_o, 0);
        step("R4");
        chk(wrap_evt_o == 1'b1, "R4 wrap sets flag", wrap_evt_o, 1);
        incr_i = 32'h0;
        for (int i = 0; i < 4; i++) step("R7");
        chk(wrap_evt_o == 1'b1, "R7 sticky", wrap_evt_o, 1);
        evt_ack_i = 1'b1;
        step("R7");
        evt_ack_i = 1'b0;
        chk(wrap_evt_o == 1'b0, "R7 ack clears", wrap_evt_o, 0);
        incr_i = 32'h8000_0000;
        evt_ack_i = 1'b1;
        step("R7");
        step("R7");
        evt_ack_i = 1'b0;
        chk(wrap_evt_o == 1'b1, "R7 set beats ack", wrap_evt_o, 1);
        drive_en_i = 1'b0;
        step("R1");
        chk(wrap_evt_o == 1'b0 && clk_pin_o == 1'b0, "R1 disable clears", wrap_evt_o, 0);
    endtask

    task automatic t_incr_change();
        restart(16'd4, 32'h4000_0000);
        for (int i = 0; i < 10; i++) step("R9");
        chk(clk_pin_o == 1'b1, "R9 before change", clk_pin_o, 1);
        incr_i = 32'h2000_0000;
        step("R9");
        chk(clk_pin_o == 1'b1, "R9 not cleared by write", clk_pin_o, 1);
        step("R9");
        chk(clk_pin_o == 1'b1, "R9 boundary uses new incr", clk_pin_o, 1);
        for (int i = 0; i < 12; i++) step("R9");
        chk(clk_pin_o == 1'b0 && wrap_evt_o == 1'b1, "R9 wrap after four new steps",
            {clk_pin_o, wrap_evt_o}, 1);
    endtask

    initial begin
        t_reset();
        t_exact_p1();
        t_exact_p3();
        t_zero_period();
        t_frac();
        t_event();
        t_incr_change();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule